// File: doc/BRIEF.md
# Critical Access Detector

This block sits beside a data cache that is allowed to keep serving a line after that line has been invalidated by another core. Such a "stale" copy is normally harmless. Synchronization data is the exception: lock hand-offs, barrier counters and flags that another core is spinning on must be seen promptly. The detector watches every data-cache access. It decides, in the cycle of the access, whether the stale copy has to be thrown away so that a real miss is taken.

Two independent rules flag synchronization traffic.

- **Sync tag.** A per-line tag is set whenever a store-conditional touches the line. A tagged line is never served from a stale copy.
- **Polling filter.** Each access is compared with the one accepted just before it. When both carry the same PC and the same line, the access is treated as a polling loop.

Either rule, hitting a line that is currently stale, raises a discard request for that line. The request also clears the line's stale bit, so the following miss and refill start clean. The cache reports line-state changes on a separate event port: a line turning stale, an eviction, or a refill from memory.

The access interface is valid/ready. Line events take priority over accesses. While `evt_valid` is high, `acc_ready` is low and the block ignores the access entirely. The requester must hold its access until it sees `acc_ready` high on a clock edge where `acc_valid` is also high. An access is accepted on such an edge. Discard results are combinational and belong to the accepted access in the same cycle.

Top module: `critical_access_detector`

## Requirements
- R1: After reset no line is stale or tagged and no previous access is remembered, so an access raises no discard.
- R2: A store-conditional (`acc_kind` 2'b10) to a stale line raises `disc_valid` in the same cycle with `disc_cause` bit 0 (sync) set. The store-conditional also sets the line's sync tag whether or not the line was stale.
- R3: A load (`acc_kind` 2'b00) to a line whose sync tag is set and which is stale raises `disc_valid` with `disc_cause` bit 0 set, and `acc_miss` high.
- R4: An accepted access with the same `acc_pc` and `acc_line` as the previously accepted access, to a stale line, raises `disc_valid` with `disc_cause` bit 1 (poll) set. When both rules hit, `disc_cause` is 2'b11.
- R5: No discard, no cause bits and no miss are raised for an access to a line that is not stale, whatever the sync tag or polling match. `disc_cause` is 2'b00 whenever `disc_valid` is low.
- R6: The polling match compares against the immediately preceding accepted access only. An intervening access with a different PC or a different line breaks the match.
- R7: A line event with `evt_kind` 2'b01 (evict) or 2'b10 (refill) clears both the stale bit and the sync tag of `evt_line`. 2'b00 marks the line stale, and 2'b11 has no effect.
- R8: A discard clears the stale bit of its line. A following access to that line raises no discard until the line is marked stale again.
- R9: While `evt_valid` is high, `acc_ready` is low and the access raises no discard. The access also does not replace the remembered previous access.
- R10: `acc_miss` is raised only for a discarded load. A discarded store or store-conditional keeps it low.
- R11: `disc_line` carries the line index of the discarded access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present |
| acc_ready | output | 1 | Access accepted this cycle (low while a line event is applied) |
| acc_kind | input | 2 | 00 load, 01 store, 10 store-conditional, 11 treated as store |
| acc_pc | input | PC_W | PC of the accessing instruction |
| acc_line | input | IDX_W | Cache line index of the access |
| evt_valid | input | 1 | Line-state event present |
| evt_kind | input | 2 | 00 mark stale, 01 evict, 10 refill, 11 none |
| evt_line | input | IDX_W | Line index the event refers to |
| disc_valid | output | 1 | Discard the stale copy and take a real miss |
| disc_line | output | IDX_W | Line to discard |
| disc_cause | output | 2 | Bit 0 sync tag rule, bit 1 polling rule |
| acc_miss | output | 1 | Load must report a miss instead of returning data |

## Verification
The bench targets staleness gating. A design that forgot it would discard tagged or polled lines that are fresh and cause needless misses.

It separates the sync tag from the stale bit. A tagged line made stale later must still be discarded, while an eviction or refill must forget the tag. Mixing the two either leaks stale lock values or keeps discarding forever.

Polling is checked against exactly one prior access, including the case where a blocked access must not overwrite it. A design that remembered a window, or updated it during back-pressure, would flag or miss the wrong loops.

The mixed case where both rules fire is checked for the combined cause code. The check that a discard clears the stale bit catches a design that would discard the same line on every later access.

// File: rtl/cad_pkg.sv
package cad_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_SC    = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    EVT_STALE  = 2'b00,
    EVT_EVICT  = 2'b01,
    EVT_REFILL = 2'b10,
    EVT_NONE   = 2'b11
  } evt_kind_e;

  // bit 0: sync tag rule, bit 1: polling rule
  typedef struct packed {
    logic poll;
    logic sync;
  } cause_t;

endpackage

// File: rtl/cad_line_state.sv
module cad_line_state
  import cad_pkg::*;
#(
  parameter int LINES = 64,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [1:0]       evt_kind,
  input  logic [IDX_W-1:0] evt_line,
  input  logic             sc_fire,
  input  logic             clr_stale,
  input  logic [IDX_W-1:0] acc_line,
  output logic             rd_stale,
  output logic             rd_sync
);

  logic stale_q [LINES];
  logic sync_q  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic evt_hit;
    logic acc_hit;
    assign evt_hit = evt_valid && (evt_line == IDX_W'(g));
    assign acc_hit = (acc_line == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stale_q[g] <= 1'b0;
        sync_q[g]  <= 1'b0;
      end else if (evt_hit) begin
        unique case (evt_kind_e'(evt_kind))
          EVT_STALE: stale_q[g] <= 1'b1;
          EVT_EVICT, EVT_REFILL: begin
            stale_q[g] <= 1'b0;
            sync_q[g]  <= 1'b0;
          end
          default: ;
        endcase
      end else if (acc_hit) begin
        if (clr_stale) stale_q[g] <= 1'b0;
        if (sc_fire)   sync_q[g]  <= 1'b1;
      end
    end
  end

  assign rd_stale = stale_q[acc_line];
  assign rd_sync  = sync_q[acc_line];

  // R2: an accepted store-conditional leaves its line tagged
  p_sc_tags_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_fire && !evt_valid) |=> sync_q[$past(acc_line)]);

  // R7: evict or refill forgets both bits
  p_evict_forgets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_kind == EVT_EVICT || evt_kind == EVT_REFILL))
      |=> (!sync_q[$past(evt_line)] && !stale_q[$past(evt_line)]));

  // R8: a discarded line is no longer stale afterwards
  p_discard_unstales_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stale && !evt_valid) |=> !stale_q[$past(acc_line)]);

endmodule

// File: rtl/cad_poll_tracker.sv
module cad_poll_tracker #(
  parameter int PC_W  = 16,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [PC_W-1:0]  acc_pc,
  input  logic [IDX_W-1:0] acc_line,
  output logic             poll_match
);

  logic             prev_vld_q;
  logic [PC_W-1:0]  prev_pc_q;
  logic [IDX_W-1:0] prev_line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_vld_q  <= 1'b0;
      prev_pc_q   <= '0;
      prev_line_q <= '0;
    end else if (take) begin
      prev_vld_q  <= 1'b1;
      prev_pc_q   <= acc_pc;
      prev_line_q <= acc_line;
    end
  end

  assign poll_match = prev_vld_q && (acc_pc == prev_pc_q) && (acc_line == prev_line_q);

  // R6: history follows exactly the last accepted access
  p_history_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (prev_pc_q == $past(acc_pc) && prev_line_q == $past(acc_line)));

  // R9: a blocked access leaves the history untouched
  p_history_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(prev_pc_q) && $stable(prev_line_q)));

endmodule

// File: rtl/cad_decide.sv
module cad_decide
  import cad_pkg::*;
(
  input  logic       take,
  input  logic [1:0] acc_kind,
  input  logic       line_stale,
  input  logic       line_sync,
  input  logic       poll_match,
  output logic       discard,
  output logic [1:0] cause,
  output logic       miss
);

  cause_t c;

  always_comb begin
    c = '0;
    if (take && line_stale) begin
      c.sync = line_sync || (acc_kind_e'(acc_kind) == ACC_SC);
      c.poll = poll_match;
    end
  end

  assign cause   = c;
  assign discard = c.sync || c.poll;
  assign miss    = discard && (acc_kind_e'(acc_kind) == ACC_LOAD);

endmodule

// File: rtl/critical_access_detector.sv
module critical_access_detector
  import cad_pkg::*;
#(
  parameter int LINES = 64,
  parameter int PC_W  = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic [1:0]       acc_kind,
  input  logic [PC_W-1:0]  acc_pc,
  input  logic [IDX_W-1:0] acc_line,
  input  logic             evt_valid,
  input  logic [1:0]       evt_kind,
  input  logic [IDX_W-1:0] evt_line,
  output logic             disc_valid,
  output logic [IDX_W-1:0] disc_line,
  output logic [1:0]       disc_cause,
  output logic             acc_miss
);

  logic take;
  logic line_stale;
  logic line_sync;
  logic poll_match;
  logic sc_fire;

  assign acc_ready = !evt_valid;
  assign take      = acc_valid && acc_ready;
  assign sc_fire   = take && (acc_kind_e'(acc_kind) == ACC_SC);

  cad_line_state #(.LINES(LINES)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .evt_line  (evt_line),
    .sc_fire   (sc_fire),
    .clr_stale (disc_valid),
    .acc_line  (acc_line),
    .rd_stale  (line_stale),
    .rd_sync   (line_sync)
  );

  cad_poll_tracker #(.PC_W(PC_W), .IDX_W(IDX_W)) u_poll (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .acc_pc     (acc_pc),
    .acc_line   (acc_line),
    .poll_match (poll_match)
  );

  cad_decide u_decide (
    .take       (take),
    .acc_kind   (acc_kind),
    .line_stale (line_stale),
    .line_sync  (line_sync),
    .poll_match (poll_match),
    .discard    (disc_valid),
    .cause      (disc_cause),
    .miss       (acc_miss)
  );

  assign disc_line = acc_line;

  // R9: nothing is discarded while a line event holds the port
  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (!disc_valid && !acc_miss));

  // R10: a miss indication belongs to a discarded load
  p_miss_only_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss |-> (disc_valid && acc_kind == ACC_LOAD));

  // R5: cause bits never appear without a discard
  p_cause_needs_disc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_cause != 2'b00) |-> disc_valid);

  // R8: a line just discarded cannot be discarded again next cycle without a new stale event
  p_no_double_disc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_valid ##1 (disc_valid && !$past(evt_valid))) |-> (disc_line != $past(disc_line)));

endmodule

// File: tb/critical_access_detector_bench.sv
module critical_access_detector_bench;

  localparam int CLK_NS = 10;
  localparam int LINES  = 64;
  localparam int PC_W   = 16;
  localparam int IDX_W  = $clog2(LINES);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             acc_valid;
  logic             acc_ready;
  logic [1:0]       acc_kind;
  logic [PC_W-1:0]  acc_pc;
  logic [IDX_W-1:0] acc_line;
  logic             evt_valid;
  logic [1:0]       evt_kind;
  logic [IDX_W-1:0] evt_line;
  logic             disc_valid;
  logic [IDX_W-1:0] disc_line;
  logic [1:0]       disc_cause;
  logic             acc_miss;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_SC = 2'b10;
  localparam logic [1:0] E_STALE = 2'b00, E_EVICT = 2'b01, E_REFILL = 2'b10, E_NONE = 2'b11;

  always #(CLK_NS/2) clk = ~clk;

  critical_access_detector #(.LINES(LINES), .PC_W(PC_W)) u_critical_access_detector (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_kind(acc_kind),
    .acc_pc(acc_pc), .acc_line(acc_line),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_line(evt_line),
    .disc_valid(disc_valid), .disc_line(disc_line),
    .disc_cause(disc_cause), .acc_miss(acc_miss)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic line_evt(logic [1:0] k, int line);
    @(negedge clk);
    evt_valid = 1'b1;
    evt_kind  = k;
    evt_line  = line[IDX_W-1:0];
    @(posedge clk);
    #1 evt_valid = 1'b0;
  endtask

  task automatic access(logic [1:0] k, int pc, int line,
                        bit e_disc, int e_cause, bit e_miss, string req);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_kind  = k;
    acc_pc    = pc[PC_W-1:0];
    acc_line  = line[IDX_W-1:0];
    #1;
    check_eq(req, "disc_valid", int'(disc_valid), int'(e_disc));
    check_eq(req, "disc_cause", int'(disc_cause), e_cause);
    check_eq(req, "acc_miss", int'(acc_miss), int'(e_miss));
    if (e_disc) check_eq("R11", "disc_line", int'(disc_line), line);
    @(posedge clk);
    #1 acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    check_eq("R1", "acc_ready", int'(acc_ready), 1);
    access(K_LD, 'h11, 3, 0, 0, 0, "R1");
    access(K_LD, 'h11, 3, 0, 0, 0, "R1");
  endtask

  task automatic t_sc_rule;
    line_evt(E_STALE, 5);
    access(K_SC, 'h10, 5, 1, 1, 0, "R2");
    access(K_LD, 'h12, 5, 0, 0, 0, "R8");
  endtask

  task automatic t_tag_later;
    line_evt(E_STALE, 5);
    access(K_LD, 'h20, 5, 1, 1, 1, "R3");
    line_evt(E_STALE, 5);
    access(K_ST, 'h24, 5, 1, 1, 0, "R10");
  endtask

  task automatic t_poll;
    line_evt(E_STALE, 9);
    access(K_LD, 'h30, 9, 0, 0, 0, "R4");
    access(K_LD, 'h30, 9, 1, 2, 1, "R4");
    access(K_LD, 'h30, 9, 0, 0, 0, "R5");
    access(K_SC, 'h34, 40, 0, 0, 0, "R5");
    access(K_LD, 'h36, 40, 0, 0, 0, "R5");
  endtask

  task automatic t_poll_broken;
    line_evt(E_STALE, 12);
    access(K_LD, 'h40, 12, 0, 0, 0, "R6");
    access(K_LD, 'h44, 12, 0, 0, 0, "R6");
    access(K_LD, 'h40, 12, 0, 0, 0, "R6");
    access(K_LD, 'h40, 13, 0, 0, 0, "R6");
    access(K_LD, 'h40, 12, 0, 0, 0, "R6");
    access(K_LD, 'h40, 12, 1, 2, 1, "R6");
  endtask

  task automatic t_forget;
    line_evt(E_EVICT, 5);
    line_evt(E_STALE, 5);
    access(K_LD, 'h50, 5, 0, 0, 0, "R7");
    access(K_SC, 'h52, 20, 0, 0, 0, "R7");
    line_evt(E_REFILL, 20);
    line_evt(E_STALE, 20);
    access(K_LD, 'h54, 20, 0, 0, 0, "R7");
    line_evt(E_STALE, 22);
    line_evt(E_EVICT, 22);
    access(K_SC, 'h56, 22, 0, 0, 0, "R7");
    line_evt(E_STALE, 23);
    line_evt(E_NONE, 23);
    access(K_SC, 'h58, 23, 1, 1, 0, "R7");
  endtask

  task automatic t_backpressure;
    line_evt(E_STALE, 25);
    access(K_LD, 'h60, 25, 0, 0, 0, "R9");
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = E_NONE; evt_line = 6'd1;
    acc_valid = 1'b1; acc_kind = K_SC; acc_pc = 16'h99; acc_line = 6'd25;
    #1;
    check_eq("R9", "acc_ready", int'(acc_ready), 0);
    check_eq("R9", "disc_valid", int'(disc_valid), 0);
    @(posedge clk);
    #1 begin evt_valid = 1'b0; acc_valid = 1'b0; end
    access(K_LD, 'h60, 25, 1, 2, 1, "R9");
  endtask

  task automatic t_both_rules;
    line_evt(E_STALE, 30);
    access(K_SC, 'h70, 30, 1, 1, 0, "R2");
    line_evt(E_STALE, 30);
    access(K_LD, 'h70, 30, 1, 3, 1, "R4");
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_kind = '0; acc_pc = '0; acc_line = '0;
    evt_valid = 1'b0; evt_kind = '0; evt_line = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_sc_rule();
    t_tag_later();
    t_poll();
    t_poll_broken();
    t_forget();
    t_backpressure();
    t_both_rules();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule